// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block watches the serial data line of an HDLC receiver. Each cycle in which the bit-valid strobe is high, it consumes one received bit. From the stream it keeps two live conditions. The first is that flags are being received. The second is that the line is idle, meaning fifteen or more ones have arrived in a row. Both conditions are shown in an 8-bit read-only status byte. Alongside it, the block gives one-clock event pulses when a run of flags begins, when that run ends and when the line goes idle.

A flag is the eight-bit sequence 0,1,1,1,1,1,1,0 seen in a sliding window over the most recent received bits. Once a flag is seen, the block checks each following group of eight bits, counted from the last flag, for another flag. The run ends at the first group that is not a flag. A run also ends as soon as seven ones arrive in a row, so a flag run followed by an idle line reports its end before the idle event. The status bits show the present state of the line. They are not sticky history.

The block does not decode frames. It does no zero-bit deletion and no CRC checking, and it has no buffers and no modem control signals.

Top module: `hdlc_rx_line_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the status byte becomes 0x00 after that edge and all three event outputs are low.
- R2: Status bit 0 is the flag-run bit and status bit 1 is the idle bit. Bits 7 to 2 always read zero.
- R3: After the edge that consumes the bit completing the sequence 0,1,1,1,1,1,1,0 (oldest bit first), status bit 0 is high. If it was low before that edge, `flag_start_o` pulses high for that one clock.
- R4: While the flag-run bit is high, the eighth bit after the last flag closes a group. If that group is not a flag, status bit 0 clears and `flag_end_o` pulses for one clock.
- R5: The edge that consumes the fifteenth consecutive one sets status bit 1 and pulses `idle_evt_o` once. Further ones raise no more idle events.
- R6: Any received zero restarts the count of consecutive ones and clears status bit 1.
- R7: A seventh consecutive one received while the flag-run bit is high clears it and pulses `flag_end_o`, so the end of a flag run comes before the idle event.
- R8: On cycles with `rx_valid` low, the status byte holds and no event pulses.
- R9: The status byte and the events are registered. They change on the edge that consumes the bit, and each event is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_valid | input | 1 | High when `rx_bit` holds a new bit to consume |
| status_o | output | 8 | Live status: bit 0 flag run, bit 1 idle, rest zero |
| flag_start_o | output | 1 | One-clock pulse when a flag run begins |
| flag_end_o | output | 1 | One-clock pulse when a flag run ends |
| idle_evt_o | output | 1 | One-clock pulse when the line becomes idle |

## Verification
A wrong sliding window or a miscounted group phase shows up as a flag bit that rises late, falls one group early or late, or never falls. This appears at most eight bits after the fault, at the next group boundary. A consecutive-ones count that is off by one moves the idle bit and the idle event by one consumed bit. It can also swap the order of the end-of-run and idle events when a flag run runs into an idle line. The reference model is compared with every output after every clock, so each such slip is reported on the first clock where it changes a port.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;
  localparam int unsigned FLAG_LEN   = 8;
  localparam logic [FLAG_LEN-1:0] FLAG_PATTERN = 8'h7E;
  localparam int unsigned ST_FLAG    = 0;
  localparam int unsigned ST_IDLE    = 1;
endpackage

// File: rtl/hdlc_flag_window.sv
module hdlc_flag_window
  import hdlc_mon_pkg::*;
#(
  parameter int unsigned WIN_W = FLAG_LEN,
  parameter logic [WIN_W-1:0] PATTERN = FLAG_PATTERN
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic valid_in,
  output logic match_o
);
  // Window resets to all ones: the pattern has a zero at its oldest
  // position, so no partial fill can match before a real flag arrives.
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_next;

  assign win_next = {win_q[WIN_W-2:0], bit_in};
  assign match_o  = valid_in && (win_next == PATTERN);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '1;
    end else if (valid_in) begin
      win_q <= win_next;
    end
  end
endmodule

// File: rtl/hdlc_ones_run.sv
module hdlc_ones_run #(
  parameter int unsigned IDLE_ONES  = 15,
  parameter int unsigned ABORT_ONES = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic valid_in,
  output logic abort_hit_o,
  output logic idle_o,
  output logic idle_evt_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_ONES + 1);
  localparam logic [CNT_W-1:0] IDLE_PRE  = CNT_W'(IDLE_ONES - 1);
  localparam logic [CNT_W-1:0] ABORT_PRE = CNT_W'(ABORT_ONES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(IDLE_ONES);

  logic [CNT_W-1:0] cnt_q;
  logic             one_in;
  logic             zero_in;
  logic             idle_hit;

  assign one_in      = valid_in && bit_in;
  assign zero_in     = valid_in && !bit_in;
  assign idle_hit    = one_in && (cnt_q == IDLE_PRE);
  assign abort_hit_o = one_in && (cnt_q == ABORT_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      idle_o     <= 1'b0;
      idle_evt_o <= 1'b0;
    end else begin
      idle_evt_o <= idle_hit;
      if (zero_in) begin
        cnt_q  <= '0;
        idle_o <= 1'b0;
      end else if (one_in) begin
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (idle_hit) idle_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_flag_tracker.sv
module hdlc_flag_tracker
  import hdlc_mon_pkg::*;
#(
  parameter int unsigned GROUP_LEN = FLAG_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_in,
  input  logic match_in,
  input  logic abort_in,
  output logic active_o,
  output logic start_o,
  output logic end_o
);
  localparam int unsigned PH_W = $clog2(GROUP_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_LEN - 1);

  logic [PH_W-1:0] phase_q;
  logic            boundary;

  assign boundary = valid_in && (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      active_o <= 1'b0;
      start_o  <= 1'b0;
      end_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      if (match_in) begin
        start_o  <= !active_o;
        active_o <= 1'b1;
        phase_q  <= '0;
      end else if (valid_in && active_o) begin
        if (boundary || abort_in) begin
          active_o <= 1'b0;
          end_o    <= 1'b1;
          phase_q  <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_line_monitor.sv
module hdlc_rx_line_monitor
  import hdlc_mon_pkg::*;
#(
  parameter int unsigned STATUS_W   = 8,
  parameter int unsigned IDLE_ONES  = 15,
  parameter int unsigned ABORT_ONES = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit,
  input  logic                rx_valid,
  output logic [STATUS_W-1:0] status_o,
  output logic                flag_start_o,
  output logic                flag_end_o,
  output logic                idle_evt_o
);
  logic match_w;
  logic abort_w;
  logic flag_active_w;
  logic idle_w;

  hdlc_flag_window #(
    .WIN_W   (FLAG_LEN),
    .PATTERN (FLAG_PATTERN)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (rx_bit),
    .valid_in (rx_valid),
    .match_o  (match_w)
  );

  hdlc_ones_run #(
    .IDLE_ONES  (IDLE_ONES),
    .ABORT_ONES (ABORT_ONES)
  ) u_ones (
    .clk         (clk),
    .rst         (rst),
    .bit_in      (rx_bit),
    .valid_in    (rx_valid),
    .abort_hit_o (abort_w),
    .idle_o      (idle_w),
    .idle_evt_o  (idle_evt_o)
  );

  hdlc_flag_tracker #(
    .GROUP_LEN (FLAG_LEN)
  ) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .valid_in (rx_valid),
    .match_in (match_w),
    .abort_in (abort_w),
    .active_o (flag_active_w),
    .start_o  (flag_start_o),
    .end_o    (flag_end_o)
  );

  for (genvar i = 0; i < STATUS_W; i++) begin : g_status
    if (i == ST_FLAG) begin : g_flag
      assign status_o[i] = flag_active_w;
    end else if (i == ST_IDLE) begin : g_idle
      assign status_o[i] = idle_w;
    end else begin : g_zero
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_rx_line_monitor_chk.sv
module hdlc_rx_line_monitor_chk #(
  parameter int unsigned STATUS_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                rx_valid,
  input logic [STATUS_W-1:0] status_o,
  input logic                flag_start_o,
  input logic                flag_end_o,
  input logic                idle_evt_o
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[STATUS_W-1:2] == '0); // R2
  AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag_start_o |-> status_o[0]); // R3
  AST_END_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag_end_o |-> !status_o[0]); // R4
  AST_IDLE_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    idle_evt_o |-> status_o[1]); // R5
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    status_o[1] |-> !status_o[0]); // R7
  AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(status_o) && !flag_start_o && !flag_end_o && !idle_evt_o)); // R8
  AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    flag_start_o |=> !flag_start_o); // R9
  AST_IDLE_EVT_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    idle_evt_o |=> !idle_evt_o); // R9
endmodule

bind hdlc_rx_line_monitor hdlc_rx_line_monitor_chk #(
  .STATUS_W (STATUS_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_valid     (rx_valid),
  .status_o     (status_o),
  .flag_start_o (flag_start_o),
  .flag_end_o   (flag_end_o),
  .idle_evt_o   (idle_evt_o)
);

// File: tb/hdlc_rx_line_monitor_test.sv
`timescale 1ns/1ps
module hdlc_rx_line_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] status_o;
  logic       flag_start_o, flag_end_o, idle_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_hist[$];
  int m_ones, m_phase;
  bit m_active, m_idle, m_start, m_end, m_ievt;
  int cyc = 0;
  int last_end_cyc, last_idle_cyc;

  always #5 clk = ~clk;

  hdlc_rx_line_monitor uut (
    .clk (clk), .rst (rst), .rx_bit (rx_bit), .rx_valid (rx_valid),
    .status_o (status_o), .flag_start_o (flag_start_o),
    .flag_end_o (flag_end_o), .idle_evt_o (idle_evt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit hist_is_flag();
    int pat[8] = '{0, 1, 1, 1, 1, 1, 1, 0};
    if (m_hist.size() < 8) return 0;
    for (int k = 0; k < 8; k++)
      if (m_hist[m_hist.size() - 8 + k] != pat[k]) return 0;
    return 1;
  endfunction

  task automatic model_update(input bit r, input bit b, input bit v);
    bit abort_now;
    m_start = 0; m_end = 0; m_ievt = 0;
    if (r) begin
      m_hist.delete(); m_ones = 0; m_phase = 0; m_active = 0; m_idle = 0;
    end else if (v) begin
      m_hist.push_back(b);
      if (m_hist.size() > 8) void'(m_hist.pop_front());
      abort_now = 0;
      if (b) begin
        if (m_ones < 1000) m_ones++;
        if (m_ones == 15) begin m_idle = 1; m_ievt = 1; end
        abort_now = (m_ones == 7);
      end else begin
        m_ones = 0; m_idle = 0;
      end
      if (hist_is_flag()) begin
        m_start = !m_active; m_active = 1; m_phase = 0;
      end else if (m_active) begin
        m_phase++;
        if (m_phase == 8 || abort_now) begin
          m_active = 0; m_end = 1;
        end
      end
    end
  endtask

  task automatic compare(input bit v);
    string tag8;
    tag8 = v ? "" : " R8";
    check(status_o[7:2] == 0, {"R2 upper bits", tag8}, status_o[7:2], 0);
    check(status_o[0] == m_active, {"R3 R4 flag bit", tag8}, status_o[0], m_active);
    check(status_o[1] == m_idle, {"R5 R6 idle bit", tag8}, status_o[1], m_idle);
    check(flag_start_o == m_start, {"R3 R9 flag start", tag8}, flag_start_o, m_start);
    check(flag_end_o == m_end, {"R4 R9 flag end", tag8}, flag_end_o, m_end);
    check(idle_evt_o == m_ievt, {"R5 R9 idle event", tag8}, idle_evt_o, m_ievt);
    if (flag_end_o) last_end_cyc = cyc;
    if (idle_evt_o) last_idle_cyc = cyc;
  endtask

  task automatic step(input bit b, input bit v);
    rx_bit = b; rx_valid = v;
    @(posedge clk);
    cyc++;
    model_update(rst, b, v);
    @(negedge clk);
    compare(v);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int k = 0; k < 8; k++) step(d[k], 1'b1);
  endtask

  task automatic send_ones(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int ievt_cnt;
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
    // R1: reset state
    check(status_o == 8'h00 && !flag_start_o && !flag_end_o && !idle_evt_o,
          "R1 reset state", status_o, 0);
    rst = 1'b0;

    // R5: long run of ones, exactly one idle event
    ievt_cnt = 0;
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 1'b1);
      if (idle_evt_o) ievt_cnt++;
      if (k == 13) check(status_o[1] == 1'b0, "R5 idle not before 15 ones", status_o[1], 0);
      if (k == 14) check(status_o[1] == 1'b1, "R5 idle after 15 ones", status_o[1], 1);
    end
    check(ievt_cnt == 1, "R5 single idle event", ievt_cnt, 1);

    // R6: zero clears idle
    step(1'b0, 1'b1);
    check(status_o[1] == 1'b0, "R6 zero clears idle", status_o[1], 0);

    // R3 R4: extra opening flag, frame, closing flag, data ends run
    send_byte(8'h7E);
    check(status_o[0] == 1'b1, "R3 flag bit after flag", status_o[0], 1);
    send_byte(8'h7E);
    send_byte(8'h12);
    check(status_o[0] == 1'b0, "R4 flag run ended by data", status_o[0], 0);
    send_byte(8'h34); send_byte(8'h03); send_byte(8'h55); send_byte(8'hA0);
    send_byte(8'h5B); send_byte(8'hC4);
    send_byte(8'h7E);
    check(status_o[0] == 1'b1, "R3 closing flag seen", status_o[0], 1);

    // R7: flag run into idle line, end before idle
    last_end_cyc = -1; last_idle_cyc = -1;
    send_ones(16);
    check(last_end_cyc > 0 && last_idle_cyc > last_end_cyc,
          "R7 end of run precedes idle", last_end_cyc, last_idle_cyc);

    // R8: gaps with valid low hold everything
    step(1'b0, 1'b1);
    send_byte(8'h7E);
    for (int k = 0; k < 5; k++) begin
      step(k[0], 1'b0);
      check(status_o[0] == 1'b1, "R8 flag held when not valid", status_o[0], 1);
    end

    // mixed traffic with random valid gaps
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) step(1'b1, 1'b0);
      else if (r < 35) send_byte(8'h7E);
      else if (r < 40) send_ones(16);
      else step($urandom_range(0, 1) == 1, 1'b1);
    end

    // R1: reset mid-traffic
    send_byte(8'h7E);
    rst = 1'b1;
    step(1'b1, 1'b1);
    check(status_o == 8'h00, "R1 reset clears status", status_o, 0);
    rst = 1'b0;
    step(1'b1, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule